// File: doc/BRIEF.md
# Linked-List DMA Channel Controller

This block is one DMA channel. It copies 16-bit halfwords from a source address to a destination address on a synchronous memory bus. For each halfword it issues a read request and then a write request. Software programs the channel through a small register port. It then starts the channel by writing the control register with the enable bit set.

In direct mode the channel runs the single block that software has programmed. In linked-list mode the channel first loads its whole register set from a descriptor in memory, found at the list address. When that block finishes, it follows the next-list-address field to the next descriptor. A chain of blocks therefore runs with no further software action.

The memory port uses a valid/ready request channel. Once the channel raises `mem_req_valid`, the address, direction and write data stay unchanged until the cycle in which `mem_req_ready` is high; that cycle is the handshake. A write completes at its handshake. A read returns its data later as a one-cycle `mem_rsp_valid` pulse, and the channel always accepts it. Only one request is ever outstanding.

Top module: `ll_dma_channel`

## Requirements
- R1: After reset, `busy`, `done`, `irq` and `mem_req_valid` are low, and all eight registers read back as zero.
- R2: In direct mode, each unit moved is one read at the source address followed by one write of the same data at the destination address. After each write, source and destination each advance by 2 and the length drops by 1.
- R3: A block ends when the length reaches zero. At the end of the last block, the channel clears control bit 0 (enable) and pulses `done` high for exactly one cycle. `irq` pulses together with `done` only when control bit 2 (interrupt enable) is set.
- R4: If the length is zero when the channel starts, it finishes with `done` and issues no memory request.
- R5: Writing the control register with bit 1 set starts linked-list mode. The channel reads eight halfwords at list address +0, +2, … +14, in this order: control, length, destination low, destination high, source low, source high, next-list low, next-list high. Control bits 0 and 1 stay set after the fetch.
- R6: In linked-list mode, at the end of each block the channel fetches the next descriptor when the list address is nonzero, and finishes otherwise. This includes a block whose length is zero. Starting linked-list mode with a list address of zero finishes at once, with no memory request.
- R7: Register writes are ignored while `busy` is high, including during a descriptor fetch.
- R8: Once `mem_req_valid` is high, it stays high with a stable address, direction and write data until a cycle with `mem_req_ready` high. A read response may arrive any number of cycles after the read handshake.
- R9: Register offsets are: 0 control, 1 length, 2/3 destination low/high, 4/5 source low/high, 6/7 list address low/high. Each high register keeps only address bits 23:16 in its bits 7:0 and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 24 | Byte address of the request |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_rdata | input | 16 | Read data |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle interrupt pulse, qualified by control bit 2 |

## Verification
The hardest situation to reach from the ports is a register write that lands during a descriptor fetch in the middle of a chain, while the memory stalls requests and delays responses. The bench reaches it by writing the list-address register right after starting a chain under random back-pressure. It then checks that the whole chain still ran, by comparing the total read count and the final readback with the expected values. A zero-length descriptor inside the chain and a list address of zero at start cover the two ways a chain can end without moving data.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
  localparam int REG_COUNT = 8;

  localparam logic [2:0] IDX_CTL    = 3'd0;
  localparam logic [2:0] IDX_LEN    = 3'd1;
  localparam logic [2:0] IDX_DST_LO = 3'd2;
  localparam logic [2:0] IDX_DST_HI = 3'd3;
  localparam logic [2:0] IDX_SRC_LO = 3'd4;
  localparam logic [2:0] IDX_SRC_HI = 3'd5;
  localparam logic [2:0] IDX_LST_LO = 3'd6;
  localparam logic [2:0] IDX_LST_HI = 3'd7;

  localparam int CTL_EN = 0;
  localparam int CTL_LL = 1;
  localparam int CTL_IE = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_LAUNCH, S_FETCH_REQ, S_FETCH_WAIT, S_CHECK_LEN,
    S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_BLOCK_END, S_FINISH
  } seq_state_e;
endpackage

// File: rtl/ll_dma_regfile.sv
module ll_dma_regfile
  import ll_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        sw_idx,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              ld_we,
  input  logic [2:0]        ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              step,
  input  logic              finish,
  input  logic [2:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctl,
  output logic [DATA_W-1:0] len,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [ADDR_W-1:0] lst
);
  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int STRIDE = DATA_W / 8;

  logic [REG_COUNT-1:0][DATA_W-1:0] word;
  logic [REG_COUNT-1:0][DATA_W-1:0] step_word;
  logic [REG_COUNT-1:0]             step_hit;
  logic [ADDR_W-1:0]                src_nxt, dst_nxt;

  assign ctl = word[IDX_CTL];
  assign len = word[IDX_LEN];
  assign dst = {word[IDX_DST_HI][HI_W-1:0], word[IDX_DST_LO]};
  assign src = {word[IDX_SRC_HI][HI_W-1:0], word[IDX_SRC_LO]};
  assign lst = {word[IDX_LST_HI][HI_W-1:0], word[IDX_LST_LO]};
  assign rd_data = word[rd_idx];

  assign src_nxt = src + ADDR_W'(STRIDE);
  assign dst_nxt = dst + ADDR_W'(STRIDE);

  always_comb begin
    step_word = word;
    step_hit  = '0;
    step_word[IDX_LEN] = len - DATA_W'(1);
    step_word[IDX_DST_LO] = dst_nxt[DATA_W-1:0];
    step_word[IDX_DST_HI] = DATA_W'(dst_nxt[ADDR_W-1:DATA_W]);
    step_word[IDX_SRC_LO] = src_nxt[DATA_W-1:0];
    step_word[IDX_SRC_HI] = DATA_W'(src_nxt[ADDR_W-1:DATA_W]);
    step_hit[IDX_LEN]    = 1'b1;
    step_hit[IDX_DST_LO] = 1'b1;
    step_hit[IDX_DST_HI] = 1'b1;
    step_hit[IDX_SRC_LO] = 1'b1;
    step_hit[IDX_SRC_HI] = 1'b1;
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam bit IS_HI = (i == 3) || (i == 5) || (i == 7);
    localparam logic [DATA_W-1:0] KEEP =
      IS_HI ? ({DATA_W{1'b1}} >> (DATA_W - HI_W)) : {DATA_W{1'b1}};
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld_we && ld_idx == 3'(i)) begin
        q <= ld_data & KEEP;
      end else if (sw_we && sw_idx == 3'(i)) begin
        q <= sw_data & KEEP;
      end else if (step && step_hit[i]) begin
        q <= step_word[i] & KEEP;
      end else if (finish && i == int'(IDX_CTL)) begin
        q[CTL_EN] <= 1'b0;
      end
    end

    assign word[i] = q;
  end
endmodule

// File: rtl/ll_dma_sequencer.sv
module ll_dma_sequencer
  import ll_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ctl_ll,
  input  logic [DATA_W-1:0] len,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] lst,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              ld_we,
  output logic [2:0]        ld_idx,
  output logic [DATA_W-1:0] ld_data,
  output logic              step,
  output logic              finish,
  output logic              busy
);
  localparam int STRIDE = DATA_W / 8;
  localparam logic [DATA_W-1:0] CTL_FORCE = DATA_W'((1 << CTL_EN) | (1 << CTL_LL));
  localparam logic [2:0] LAST_IDX = 3'(REG_COUNT - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] fptr_q;
  logic [2:0]        fidx_q;
  logic [DATA_W-1:0] buf_q;

  always_comb begin
    state_d       = state_q;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = src;
    ld_we         = 1'b0;
    step          = 1'b0;
    unique case (state_q)
      S_IDLE:       if (start) state_d = S_LAUNCH;
      S_LAUNCH: begin
        if (ctl_ll) state_d = (lst == '0) ? S_FINISH : S_FETCH_REQ;
        else        state_d = S_CHECK_LEN;
      end
      S_FETCH_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = fptr_q;
        if (mem_req_ready) state_d = S_FETCH_WAIT;
      end
      S_FETCH_WAIT: begin
        if (mem_rsp_valid) begin
          ld_we   = 1'b1;
          state_d = (fidx_q == LAST_IDX) ? S_CHECK_LEN : S_FETCH_REQ;
        end
      end
      S_CHECK_LEN:  state_d = (len == '0) ? S_BLOCK_END : S_RD_REQ;
      S_RD_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src;
        if (mem_req_ready) state_d = S_RD_WAIT;
      end
      S_RD_WAIT:    if (mem_rsp_valid) state_d = S_WR_REQ;
      S_WR_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst;
        if (mem_req_ready) begin
          step    = 1'b1;
          state_d = (len == DATA_W'(1)) ? S_BLOCK_END : S_RD_REQ;
        end
      end
      S_BLOCK_END:  state_d = (ctl_ll && lst != '0) ? S_FETCH_REQ : S_FINISH;
      S_FINISH:     state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fptr_q  <= '0;
      fidx_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_LAUNCH || state_q == S_BLOCK_END) begin
        fptr_q <= lst;
        fidx_q <= '0;
      end
      if (state_q == S_FETCH_REQ && mem_req_ready) fptr_q <= fptr_q + ADDR_W'(STRIDE);
      if (state_q == S_FETCH_WAIT && mem_rsp_valid) fidx_q <= fidx_q + 3'd1;
      if (state_q == S_RD_WAIT && mem_rsp_valid) buf_q <= mem_rsp_rdata;
    end
  end

  assign ld_idx        = fidx_q;
  assign ld_data       = (fidx_q == IDX_CTL) ? (mem_rsp_rdata | CTL_FORCE) : mem_rsp_rdata;
  assign mem_req_wdata = buf_q;
  assign finish        = (state_q == S_FINISH);
  assign busy          = (state_q != S_IDLE);
endmodule

// File: rtl/ll_dma_channel.sv
module ll_dma_channel
  import ll_dma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  logic              sw_we, start;
  logic              ld_we, step, finish;
  logic [2:0]        ld_idx;
  logic [DATA_W-1:0] ld_data;
  logic [DATA_W-1:0] ctl_w, len_w;
  logic [ADDR_W-1:0] src_w, dst_w, lst_w;

  assign sw_we = reg_we && !busy;
  assign start = sw_we && (reg_addr == IDX_CTL) && reg_wdata[CTL_EN];

  ll_dma_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_idx(reg_addr), .sw_data(reg_wdata),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .step(step), .finish(finish),
    .rd_idx(reg_addr), .rd_data(reg_rdata),
    .ctl(ctl_w), .len(len_w), .src(src_w), .dst(dst_w), .lst(lst_w)
  );

  ll_dma_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl_ll(ctl_w[CTL_LL]),
    .len(len_w), .src(src_w), .dst(dst_w), .lst(lst_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .step(step), .finish(finish), .busy(busy)
  );

  assign done = finish;
  assign irq  = finish && ctl_w[CTL_IE];
endmodule

// File: rtl/ll_dma_checker.sv
module ll_dma_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              irq,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [DATA_W-1:0] ctl_w,
  input logic [DATA_W-1:0] len_w
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_req_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  assert_len_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> (len_w == $past(len_w) - DATA_W'(1)));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_clears_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ctl_w[0]);

  assert_irq_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  assert_busy_ends_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

bind ll_dma_channel ll_dma_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .irq(irq),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .ctl_w(ctl_w), .len_w(len_w)
);

// File: tb/tb_ll_dma_channel.sv
module tb_ll_dma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [23:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_rdata = '0;
  logic        busy, done, irq;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, irq_cnt = 0;
  bit bp_on = 1'b0;
  bit pend = 1'b0;
  int pend_dly = 0;
  logic [15:0] pend_data = '0;
  logic [15:0] mem [0:4095];

  always #5 clk = ~clk;

  ll_dma_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .busy(busy), .done(done), .irq(irq)
  );

  function automatic int mi(input logic [23:0] a);
    return int'(a[12:1]);
  endfunction

  function automatic logic [23:0] end_addr(input logic [23:0] base, input int n);
    return base + 24'(2 * n);
  endfunction

  // Memory model: decides the inputs for the coming rising edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      pend = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = pend_data;
          pend = 1'b0;
        end else pend_dly--;
      end
      mem_req_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mi(mem_req_addr)] = mem_req_wdata;
          wr_cnt++;
        end else begin
          pend = 1'b1;
          pend_data = mem[mi(mem_req_addr)];
          pend_dly = int'($urandom % 3);
          rd_cnt++;
        end
      end
      if (done) done_cnt++;
      if (irq) irq_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_done(input int d0, input string tag);
    int t = 0;
    while (done_cnt == d0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk({tag, " watchdog"}, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_addr(input logic [2:0] lo, input logic [23:0] a);
    reg_wr(lo, a[15:0]);
    reg_wr(lo + 3'd1, {8'h00, a[23:16]});
  endtask

  task automatic check_addr(input logic [2:0] lo, input logic [23:0] exp, input string tag);
    logic [15:0] l, h;
    reg_rd(lo, l);
    reg_rd(lo + 3'd1, h);
    chk(tag, {8'h00, h[7:0], l}, {8'h00, exp});
    chk({tag, " R9 high zero-extended"}, {24'h0, h[15:8]}, 0);
  endtask

  task automatic do_direct(input logic [23:0] s, input logic [23:0] d,
                           input int n, input bit ie, input string tag);
    int r0, w0, d0, i0, bad;
    logic [15:0] v;
    for (int k = 0; k < n; k++) begin
      mem[mi(end_addr(s, k))] = 16'($urandom);
      mem[mi(end_addr(d, k))] = 16'h0000;
    end
    set_addr(3'd4, s);
    set_addr(3'd2, d);
    reg_wr(3'd1, 16'(n));
    r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt; i0 = irq_cnt;
    reg_wr(3'd0, ie ? 16'h0005 : 16'h0001);
    wait_done(d0, tag);
    bad = 0;
    for (int k = 0; k < n; k++)
      if (mem[mi(end_addr(d, k))] !== mem[mi(end_addr(s, k))]) bad++;
    chk({tag, " R2 data copied"}, bad, 0);
    chk({tag, " R2/R4 read count"}, rd_cnt - r0, n);
    chk({tag, " R2/R4 write count"}, wr_cnt - w0, n);
    chk({tag, " R3 one done pulse"}, done_cnt - d0, 1);
    chk({tag, " R3 irq gated by bit 2"}, irq_cnt - i0, ie ? 1 : 0);
    reg_rd(3'd1, v);
    chk({tag, " R3 length zero"}, v, 0);
    reg_rd(3'd0, v);
    chk({tag, " R3 enable cleared"}, v, ie ? 16'h0004 : 16'h0000);
    check_addr(3'd4, end_addr(s, n), {tag, " R2 source advanced"});
    check_addr(3'd2, end_addr(d, n), {tag, " R2 destination advanced"});
  endtask

  task automatic put_desc(input logic [23:0] at, input logic [15:0] c, input logic [15:0] n,
                          input logic [23:0] d, input logic [23:0] s, input logic [23:0] nx);
    mem[mi(at)]      = c;
    mem[mi(at + 2)]  = n;
    mem[mi(at + 4)]  = d[15:0];
    mem[mi(at + 6)]  = {8'h00, d[23:16]};
    mem[mi(at + 8)]  = s[15:0];
    mem[mi(at + 10)] = {8'h00, s[23:16]};
    mem[mi(at + 12)] = nx[15:0];
    mem[mi(at + 14)] = {8'h00, nx[23:16]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int r0, w0, d0, i0, bad;
    void'($urandom(32'd4242));
    for (int k = 0; k < 4096; k++) mem[k] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy low", busy, 0);
    chk("R1 done low", done, 0);
    chk("R1 irq low", irq, 0);
    chk("R1 request idle", mem_req_valid, 0);
    for (int k = 0; k < 8; k++) begin
      reg_rd(3'(k), v);
      chk("R1 register zero", v, 0);
    end

    // R9 register map and high-half width
    reg_wr(3'd3, 16'hABCD);
    reg_rd(3'd3, v);
    chk("R9 high keeps 8 bits", v, 16'h00CD);
    reg_wr(3'd1, 16'h1234);
    reg_rd(3'd1, v);
    chk("R9 length readback", v, 16'h1234);

    // Directed direct-mode jobs
    do_direct(24'h000100, 24'h000800, 5, 1'b1, "direct ie");
    do_direct(24'h000140, 24'h000840, 1, 1'b0, "direct single");
    do_direct(24'h000180, 24'h000880, 0, 1'b1, "R4 zero length");

    // R7: writes during a running block are ignored
    bp_on = 1'b1;
    for (int k = 0; k < 20; k++) begin
      mem[mi(end_addr(24'h000300, k))] = 16'($urandom);
      mem[mi(end_addr(24'h000900, k))] = 16'h0;
    end
    set_addr(3'd4, 24'h000300);
    set_addr(3'd2, 24'h000900);
    reg_wr(3'd1, 16'd20);
    w0 = wr_cnt; d0 = done_cnt;
    reg_wr(3'd0, 16'h0001);
    repeat (4) @(negedge clk);
    reg_wr(3'd1, 16'd2);
    reg_wr(3'd2, 16'h0F00);
    reg_wr(3'd0, 16'h0000);
    wait_done(d0, "R7 direct");
    chk("R7 full block written", wr_cnt - w0, 20);
    check_addr(3'd2, end_addr(24'h000900, 20), "R7 destination unaffected");
    bad = 0;
    for (int k = 0; k < 20; k++)
      if (mem[mi(end_addr(24'h000900, k))] !== mem[mi(end_addr(24'h000300, k))]) bad++;
    chk("R7 data copied", bad, 0);

    // R5/R6 linked-list chain with a zero-length middle block, plus R7 during fetch
    for (int k = 0; k < 8; k++) mem[mi(end_addr(24'h000400, k))] = 16'($urandom);
    for (int k = 0; k < 8; k++) mem[mi(end_addr(24'h000C00, k))] = 16'h0;
    put_desc(24'h001000, 16'h0000, 16'd3, 24'h000C00, 24'h000400, 24'h001010);
    put_desc(24'h001010, 16'h0004, 16'd0, 24'h000D00, 24'h000500, 24'h001020);
    put_desc(24'h001020, 16'h0004, 16'd4, 24'h000C06, 24'h000406, 24'h000000);
    set_addr(3'd6, 24'h001000);
    r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt; i0 = irq_cnt;
    reg_wr(3'd0, 16'h0003);
    reg_wr(3'd6, 16'h0000);
    wait_done(d0, "R6 chain");
    chk("R5 reads: 3 descriptors + 7 units", rd_cnt - r0, 31);
    chk("R6 writes across chain", wr_cnt - w0, 7);
    chk("R6 one done for chain", done_cnt - d0, 1);
    chk("R3 irq from last descriptor", irq_cnt - i0, 1);
    bad = 0;
    for (int k = 0; k < 7; k++)
      if (mem[mi(end_addr(24'h000C00, k))] !== mem[mi(end_addr(24'h000400, k))]) bad++;
    chk("R5 chain data copied", bad, 0);
    reg_rd(3'd0, v);
    chk("R5 control from descriptor, enable cleared", v, 16'h0006);
    check_addr(3'd2, end_addr(24'h000C06, 4), "R5 destination from last descriptor");
    check_addr(3'd4, end_addr(24'h000406, 4), "R5 source from last descriptor");
    check_addr(3'd6, 24'h000000, "R6 list address ends zero");

    // R6 linked-list start with list address zero
    set_addr(3'd6, 24'h000000);
    r0 = rd_cnt; d0 = done_cnt;
    reg_wr(3'd0, 16'h0003);
    wait_done(d0, "R6 empty list");
    chk("R6 empty list no bus cycles", rd_cnt - r0, 0);
    chk("R6 empty list done", done_cnt - d0, 1);

    // Random direct jobs
    for (int j = 0; j < 10; j++) begin
      bp_on = 1'($urandom % 2);
      do_direct(24'h000100 + 24'(2 * ($urandom % 128)),
                24'h000800 + 24'(2 * ($urandom % 128)),
                1 + int'($urandom % 16), 1'($urandom % 2), "random R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule